// File: doc/BRIEF.md
# Vectored Nesting Interrupt Controller

This block gathers level-sensitive interrupt requests from a set of channels and presents them to a processor on two outputs. The normal output supports nesting. The fast output does not. Software gives each channel three settings through a small synchronous register port:

- a route bit, which sends the channel to the normal or the fast output;
- a priority from 0 to 7, where 7 is the most urgent;
- a full-width vector word.

Each channel also has its own bit in a shared enable word.

When the processor takes an interrupt, it reads a vector register. The read returns the vector word of the winning channel. A read of the normal vector register also pushes the winner's priority onto an internal stack. While a level is on that stack, requests at that priority or below are held back. A request at a strictly higher priority still raises the normal output, so higher-priority work can preempt the current handler.

At the end of service, software writes to an end register, and the data written is discarded. For the normal path this write pops one level from the stack. For the fast path it releases the single busy flag. A vector read with nothing to serve returns a programmable default vector, so that spurious entries can be caught. Stack misuse sets a sticky error bit. The stack depth and the priority on top of the stack can be read back.

Top module: `nest_intc`

## Requirements
- R1: After reset, `irq_o` and `fiq_o` are low, the enable word (byte offset 0x14) reads 0 and the status word (offset 0x18) reads 0.
- R2: A read of the normal vector register at offset 0x00 returns, one cycle later on `rdata`, the vector word of the highest-priority channel that is requesting, enabled and routed to the normal output. Equal priorities resolve to the lowest channel number. Channel n has its configuration word at 0x40+4n, with bit 3 = route (1 = fast) and bits 2:0 = priority (7 highest), and its vector word at 0x80+4n.
- R3: A normal vector read that finds a winner pushes the winner's priority. Status bits 3:0 hold the depth and bits 6:4 hold the top priority, which reads 0 when the stack is empty.
- R4: Any write to offset 0x08 pops one level, and the written data is ignored.
- R5: While the stack holds a level, normal requests at or below the top priority do not raise `irq_o`, but a strictly higher one does. Eight levels, one for each priority, can be stacked.
- R6: A read of the fast vector register at offset 0x04 returns the vector word of the highest-priority fast-routed, enabled, requesting channel and marks the fast path busy. While it is busy, `fiq_o` is low and further fast reads return the default. Any write to 0x0C clears the busy state.
- R7: A vector read with no eligible channel returns the default vector word (offset 0x10) and changes no state.
- R8: A pop with an empty stack leaves the stack unchanged and sets status bit 8. The bit stays set until software writes the status word with bit 8 = 1. A push with a full stack is treated the same way.
- R9: `irq_o` and `fiq_o` are registered and change on the first clock edge after the input or state that causes them.
- R10: A channel whose enable bit (bit n of offset 0x14) is 0 takes part in neither the output nor the vector selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW (8) | Byte offset of the register |
| wdata | input | DW (32) | Write data |
| rdata | output | DW (32) | Read data, valid the cycle after `rd_en` |
| req | input | NCH (16) | Level-sensitive channel requests |
| irq_o | output | 1 | Normal (nesting) interrupt output |
| fiq_o | output | 1 | Fast (non-nesting) interrupt output |

## Verification
The checker assumes three things about the register port:

- a normal vector read and a normal end write never fall in the same cycle;
- reset is applied at time zero;
- end writes are paired with vector reads, except where an empty pop is tested on purpose.

The bench drives only one register access per cycle, on the falling edge, so pushes and pops never coincide. It raises requests one priority at a time when filling the stack, and its only unpaired end write is the empty-stack error case.

// File: rtl/nest_intc_pkg.sv
package nest_intc_pkg;

   localparam logic [7:0] OFF_IVEC = 8'h00;
   localparam logic [7:0] OFF_FVEC = 8'h04;
   localparam logic [7:0] OFF_IEND = 8'h08;
   localparam logic [7:0] OFF_FEND = 8'h0C;
   localparam logic [7:0] OFF_DFLT = 8'h10;
   localparam logic [7:0] OFF_EN   = 8'h14;
   localparam logic [7:0] OFF_STAT = 8'h18;

   localparam int STAT_TOP_LSB = 4;
   localparam int STAT_ERR_BIT = 8;

   typedef enum logic [1:0] {
      RG_CTRL = 2'b00,
      RG_CFG  = 2'b01,
      RG_VEC  = 2'b10,
      RG_NONE = 2'b11
   } region_e;

endpackage

// File: rtl/nest_intc_arb.sv
module nest_intc_arb #(
   parameter int NCH = 16,
   parameter int PW  = 3,
   localparam int CW = $clog2(NCH)
) (
   input  logic [NCH-1:0]    valid,
   input  logic [NCH*PW-1:0] pri_flat,
   output logic              any,
   output logic [CW-1:0]     idx,
   output logic [PW-1:0]     pri
);

   // Linear scan from channel 0 upward; a later channel only replaces the
   // current pick when strictly more urgent, which keeps ties on the lowest.
   always_comb begin
      any = 1'b0;
      idx = '0;
      pri = '0;
      for (int i = 0; i < NCH; i++) begin
         if (valid[i] && (!any || pri_flat[i*PW +: PW] > pri)) begin
            idx = CW'(i);
            pri = pri_flat[i*PW +: PW];
         end
         any = any | valid[i];
      end
   end

endmodule

// File: rtl/nest_intc_stack.sv
module nest_intc_stack #(
   parameter int DEPTH = 8,
   parameter int PW    = 3,
   localparam int DCW  = $clog2(DEPTH + 1),
   localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           push,
   input  logic           pop,
   input  logic [PW-1:0]  push_pri,
   output logic [DCW-1:0] depth,
   output logic [PW-1:0]  top,
   output logic           err_pulse
);

   localparam logic [DCW-1:0] FULL_CNT = DCW'(DEPTH);
   localparam logic [DCW-1:0] ONE      = DCW'(1);

   logic [PW-1:0]  mem [DEPTH];
   logic [DCW-1:0] cnt_q;
   logic [DCW-1:0] after_pop;
   logic [DCW-1:0] cnt_d;
   logic [DCW-1:0] top_idx;
   logic           pop_err;
   logic           push_err;
   logic           push_ok;

   always_comb begin
      pop_err   = pop && (cnt_q == '0);
      after_pop = (pop && !pop_err) ? cnt_q - ONE : cnt_q;
      push_err  = push && (after_pop == FULL_CNT);
      push_ok   = push && !push_err;
      cnt_d     = push_ok ? after_pop + ONE : after_pop;
      err_pulse = pop_err | push_err;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
         cnt_q <= cnt_d;
         if (push_ok) mem[after_pop[IW-1:0]] <= push_pri;
      end
   end

   assign top_idx = cnt_q - ONE;
   assign depth   = cnt_q;
   assign top     = (cnt_q == '0) ? '0 : mem[top_idx[IW-1:0]];

endmodule

// File: rtl/nest_intc.sv
module nest_intc
   import nest_intc_pkg::*;
#(
   parameter int NCH       = 16,
   parameter int NPRI      = 8,
   parameter int DW        = 32,
   parameter int AW        = 8,
   parameter int STK_DEPTH = NPRI
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_en,
   input  logic           rd_en,
   input  logic [AW-1:0]  addr,
   input  logic [DW-1:0]  wdata,
   output logic [DW-1:0]  rdata,
   input  logic [NCH-1:0] req,
   output logic           irq_o,
   output logic           fiq_o
);

   localparam int PW  = $clog2(NPRI);
   localparam int CW  = $clog2(NCH);
   localparam int DCW = $clog2(STK_DEPTH + 1);

   // ---------------- elaboration checks ----------------
   if (NCH < 2 || NCH > 16) begin : g_bad_nch
      $error("NCH must lie in 2..16");
   end
   if (NPRI < 2 || (1 << PW) != NPRI) begin : g_bad_npri
      $error("NPRI must be a power of two, at least 2");
   end
   if (AW < 8) begin : g_bad_aw
      $error("AW must be at least 8");
   end
   if (DW < STAT_ERR_BIT + 1 || DW < NCH || DW < PW + 1) begin : g_bad_dw
      $error("DW too narrow for status, enable or config fields");
   end
   if (DCW > STAT_TOP_LSB || STAT_TOP_LSB + PW > STAT_ERR_BIT) begin : g_bad_stat
      $error("status fields overlap for this stack depth or priority width");
   end
   if (STK_DEPTH < 1) begin : g_bad_depth
      $error("STK_DEPTH must be positive");
   end

   // ---------------- address decode ----------------
   region_e        region;
   logic [CW-1:0]  chan;
   logic           word_ok;
   logic [7:0]     off8;

   assign off8    = addr[7:0];
   assign region  = region_e'(addr[7:6]);
   assign chan    = addr[2 +: CW];
   assign word_ok = (addr[1:0] == 2'b00);

   // ---------------- per-channel configuration ----------------
   logic [NCH-1:0]    route_q;
   logic [NCH*PW-1:0] pri_flat;
   logic [DW-1:0]     vec_q [NCH];
   logic [NCH-1:0]    en_q;

   for (genvar c = 0; c < NCH; c++) begin : g_chan
      logic cfg_hit;
      logic vec_hit;
      assign cfg_hit = wr_en && word_ok && region == RG_CFG && chan == CW'(c);
      assign vec_hit = wr_en && word_ok && region == RG_VEC && chan == CW'(c);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            route_q[c]          <= 1'b0;
            pri_flat[c*PW +: PW] <= '0;
            vec_q[c]            <= '0;
         end else begin
            if (cfg_hit) begin
               route_q[c]          <= wdata[PW];
               pri_flat[c*PW +: PW] <= wdata[PW-1:0];
            end
            if (vec_hit) vec_q[c] <= wdata;
         end
      end
   end

   // ---------------- priority stack ----------------
   logic           stk_push;
   logic           stk_pop;
   logic [DCW-1:0] stk_depth;
   logic [PW-1:0]  stk_top;
   logic           stk_err;
   logic           stk_empty;

   assign stk_empty = (stk_depth == '0);

   // ---------------- eligibility and selection ----------------
   logic [NCH-1:0] irq_elig;
   logic [NCH-1:0] fiq_elig;
   logic           irq_any;
   logic [CW-1:0]  irq_idx;
   logic [PW-1:0]  irq_pri;
   logic           fiq_any;
   logic [CW-1:0]  fiq_idx;
   logic [PW-1:0]  fiq_pri;

   always_comb begin
      for (int i = 0; i < NCH; i++) begin
         irq_elig[i] = req[i] && en_q[i] && !route_q[i] &&
                       (stk_empty || pri_flat[i*PW +: PW] > stk_top);
         fiq_elig[i] = req[i] && en_q[i] && route_q[i];
      end
   end

   nest_intc_arb #(.NCH(NCH), .PW(PW)) u_irq_arb (
      .valid    (irq_elig),
      .pri_flat (pri_flat),
      .any      (irq_any),
      .idx      (irq_idx),
      .pri      (irq_pri)
   );

   nest_intc_arb #(.NCH(NCH), .PW(PW)) u_fiq_arb (
      .valid    (fiq_elig),
      .pri_flat (pri_flat),
      .any      (fiq_any),
      .idx      (fiq_idx),
      .pri      (fiq_pri)
   );

   // ---------------- control registers ----------------
   logic          ivec_rd;
   logic          fvec_rd;
   logic          iend_wr;
   logic          fend_wr;
   logic          fiq_take;
   logic          fiq_busy_q;
   logic          err_q;
   logic          err_clr;
   logic [DW-1:0] dflt_q;

   assign ivec_rd  = rd_en && off8 == OFF_IVEC;
   assign fvec_rd  = rd_en && off8 == OFF_FVEC;
   assign iend_wr  = wr_en && off8 == OFF_IEND;
   assign fend_wr  = wr_en && off8 == OFF_FEND;
   assign fiq_take = fvec_rd && fiq_any && !fiq_busy_q;
   assign err_clr  = wr_en && off8 == OFF_STAT && wdata[STAT_ERR_BIT];
   assign stk_push = ivec_rd && irq_any;
   assign stk_pop  = iend_wr;

   nest_intc_stack #(.DEPTH(STK_DEPTH), .PW(PW)) u_stack (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (stk_push),
      .pop       (stk_pop),
      .push_pri  (irq_pri),
      .depth     (stk_depth),
      .top       (stk_top),
      .err_pulse (stk_err)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q       <= '0;
         dflt_q     <= '0;
         fiq_busy_q <= 1'b0;
         err_q      <= 1'b0;
      end else begin
         if (wr_en && off8 == OFF_EN)   en_q   <= wdata[NCH-1:0];
         if (wr_en && off8 == OFF_DFLT) dflt_q <= wdata;
         if (fend_wr)       fiq_busy_q <= 1'b0;
         else if (fiq_take) fiq_busy_q <= 1'b1;
         if (stk_err)       err_q <= 1'b1;
         else if (err_clr)  err_q <= 1'b0;
      end
   end

   // ---------------- read path ----------------
   logic [DW-1:0] rd_mux;
   logic [DW-1:0] stat_word;

   always_comb begin
      stat_word = '0;
      stat_word[DCW-1:0]                 = stk_depth;
      stat_word[STAT_TOP_LSB +: PW]      = stk_top;
      stat_word[STAT_ERR_BIT]            = err_q;
   end

   always_comb begin
      rd_mux = '0;
      unique case (region)
         RG_CFG: if (word_ok && int'(chan) < NCH) begin
            rd_mux[PW]     = route_q[chan];
            rd_mux[PW-1:0] = pri_flat[chan*PW +: PW];
         end
         RG_VEC: if (word_ok && int'(chan) < NCH) rd_mux = vec_q[chan];
         RG_CTRL: begin
            case (off8)
               OFF_IVEC: rd_mux = irq_any ? vec_q[irq_idx] : dflt_q;
               OFF_FVEC: rd_mux = (fiq_any && !fiq_busy_q) ? vec_q[fiq_idx] : dflt_q;
               OFF_DFLT: rd_mux = dflt_q;
               OFF_EN:   rd_mux = DW'(en_q);
               OFF_STAT: rd_mux = stat_word;
               default:  rd_mux = '0;
            endcase
         end
         default: rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata <= '0;
         irq_o <= 1'b0;
         fiq_o <= 1'b0;
      end else begin
         if (rd_en) rdata <= rd_mux;
         irq_o <= irq_any;
         fiq_o <= fiq_any && !fiq_busy_q;
      end
   end

endmodule

// File: rtl/nest_intc_chk.sv
module nest_intc_chk #(
   parameter int STK_DEPTH = 8,
   localparam int DCW = $clog2(STK_DEPTH + 1)
) (
   input logic           clk,
   input logic           rst_n,
   input logic           wr_en,
   input logic [7:0]     addr,
   input logic [31:0]    wdata,
   input logic           push,
   input logic           pop,
   input logic [DCW-1:0] depth,
   input logic           err,
   input logic           fiq_busy,
   input logic           fiq_o
);
   localparam logic [DCW-1:0] FULL_CNT = DCW'(STK_DEPTH);

   a_r3_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop && depth != FULL_CNT) |=> depth == $past(depth) + DCW'(1));

   a_r4_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && depth != '0) |=> depth == $past(depth) - DCW'(1));

   a_r5_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
      depth <= FULL_CNT);

   a_r8_empty_pop_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && depth == '0) |=> (err && depth == '0));

   a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !(wr_en && addr == 8'h18 && wdata[8])) |=> err);

   a_r6_fiq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (fiq_busy && $past(fiq_busy)) |-> !fiq_o);

endmodule

bind nest_intc nest_intc_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .addr     (addr[7:0]),
   .wdata    (wdata[31:0]),
   .push     (stk_push),
   .pop      (stk_pop),
   .depth    (stk_depth),
   .err      (err_q),
   .fiq_busy (fiq_busy_q),
   .fiq_o    (fiq_o)
);

// File: tb/nest_intc_tb.sv
module nest_intc_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [15:0] req = '0;
   logic        irq_o;
   logic        fiq_o;

   int total = 0;
   int fails = 0;

   int       mpri   [16];
   bit       mroute [16];
   bit [15:0] men;

   localparam logic [31:0] DFLT = 32'hDEAD_0000;

   always #4 clk = ~clk;

   nest_intc u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .req(req), .irq_o(irq_o), .fiq_o(fiq_o)
   );

   task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", r, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; wdata = 32'h5A5A_A5A5;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   task automatic settle();
      repeat (2) @(negedge clk);
   endtask

   function automatic logic [31:0] vecof(input int n);
      return 32'h0000_1000 + 32'(n) * 32'h10;
   endfunction

   function automatic logic [31:0] stat(input int d, input int t, input int e);
      return 32'(d) | (32'(t) << 4) | (32'(e) << 8);
   endfunction

   // Winner among requesting, enabled channels on the chosen route whose
   // priority exceeds floor; -1 when none.
   function automatic int winner(input logic [15:0] r, input bit fast, input int floor);
      int w = -1;
      for (int i = 0; i < 16; i++)
         if (r[i] && men[i] && mroute[i] == fast && mpri[i] > floor)
            if (w < 0 || mpri[i] > mpri[w]) w = i;
      return w;
   endfunction

   task automatic set_cfg(input int n, input int p, input bit fast);
      mpri[n] = p; mroute[n] = fast;
      wr(8'h40 + 8'(4*n), {28'd0, fast, 3'(p)});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 irq_o", 32'(irq_o), 0);
      check("R1 fiq_o", 32'(fiq_o), 0);
      rd(8'h14, d); check("R1 enable", d, 0);
      rd(8'h18, d); check("R1 status", d, 0);

      // R7 idle read returns default, no push
      wr(8'h10, DFLT);
      rd(8'h00, d); check("R7 idle irq vec", d, DFLT);
      rd(8'h04, d); check("R7 idle fiq vec", d, DFLT);
      rd(8'h18, d); check("R7 no push", d, 0);

      // configure all channels: priority (3n mod 8), normal route
      for (int n = 0; n < 16; n++) begin
         set_cfg(n, (n * 3) % 8, 1'b0);
         wr(8'h80 + 8'(4*n), vecof(n));
      end
      men = 16'hFFFF;
      wr(8'h14, 32'h0000_FFFF);
      rd(8'h14, d); check("R10 enable readback", d, 32'h0000_FFFF);

      // R2/R3/R4 sweep: single, pair, and equal-priority pair per channel
      for (int k = 0; k < 16; k++) begin
         for (int s = 0; s < 3; s++) begin
            logic [15:0] pat;
            int w;
            pat = 16'(1) << k;
            if (s == 1) pat = pat | (16'(1) << ((k + 5) % 16));
            if (s == 2) pat = pat | (16'(1) << ((k + 8) % 16));
            w = winner(pat, 1'b0, -1);
            @(negedge clk); req = pat;
            settle();
            check("R2 irq_o raised", 32'(irq_o), 1);
            rd(8'h00, d); check("R2 vector pick", d, vecof(w));
            rd(8'h18, d); check("R3 push status", d, stat(1, mpri[w], 0));
            wr(8'h08, 32'(k * 77));
            rd(8'h18, d); check("R4 pop status", d, 0);
            @(negedge clk); req = '0;
         end
      end
      settle();
      check("R2 irq_o idle", 32'(irq_o), 0);

      // R9 one-cycle registered latency
      @(negedge clk); req = 16'h0002;
      #1 check("R9 before edge", 32'(irq_o), 0);
      @(negedge clk);
      check("R9 after one edge", 32'(irq_o), 1);
      @(negedge clk); req = '0;
      #1 check("R9 held until edge", 32'(irq_o), 1);
      @(negedge clk);
      check("R9 drop after edge", 32'(irq_o), 0);

      // R10 disabled channel ignored (ch2 pri 6 disabled, ch1 pri 3 enabled)
      men = 16'hFFFB; wr(8'h14, 32'h0000_FFFB);
      @(negedge clk); req = 16'h0004;
      settle();
      check("R10 disabled no irq", 32'(irq_o), 0);
      rd(8'h00, d); check("R10 disabled vec default", d, DFLT);
      @(negedge clk); req = 16'h0006;
      settle();
      rd(8'h00, d); check("R10 enabled lower wins", d, vecof(1));
      wr(8'h08, 0);
      men = 16'hFFFF; wr(8'h14, 32'h0000_FFFF);
      @(negedge clk); req = '0;

      // R5 nesting: ch6 pri2, ch3 pri1, ch7 pri5
      @(negedge clk); req = 16'h0040;
      settle();
      rd(8'h00, d); check("R5 first level", d, vecof(6));
      settle();
      check("R5 same level masked", 32'(irq_o), 0);
      @(negedge clk); req = 16'h0048;
      settle();
      check("R5 lower masked", 32'(irq_o), 0);
      rd(8'h00, d); check("R5 masked read default", d, DFLT);
      @(negedge clk); req = 16'h00C8;
      settle();
      check("R5 higher preempts", 32'(irq_o), 1);
      rd(8'h00, d); check("R5 nested vector", d, vecof(7));
      rd(8'h18, d); check("R5 depth two", d, stat(2, 5, 0));
      wr(8'h08, 32'hFFFF_FFFF);
      rd(8'h18, d); check("R4 back to level", d, stat(1, 2, 0));
      settle();
      check("R5 pending higher reasserts", 32'(irq_o), 1);
      wr(8'h08, 0);
      @(negedge clk); req = '0;
      rd(8'h18, d); check("R4 empty again", d, 0);

      // R5 eight levels: priorities 0..7 on channels 0..7
      for (int n = 0; n < 8; n++) set_cfg(n, n, 1'b0);
      for (int n = 0; n < 8; n++) begin
         @(negedge clk); req = req | (16'(1) << n);
         settle();
         check("R5 fill irq_o", 32'(irq_o), 1);
         rd(8'h00, d); check("R5 fill vector", d, vecof(n));
      end
      rd(8'h18, d); check("R5 full status", d, stat(8, 7, 0));
      settle();
      check("R5 all masked when full", 32'(irq_o), 0);
      @(negedge clk); req = '0;
      for (int n = 7; n >= 0; n--) begin
         wr(8'h08, 0);
         rd(8'h18, d);
         check("R4 unwind", d, stat(n, (n > 0) ? n - 1 : 0, 0));
      end

      // R8 empty pop sets sticky error
      wr(8'h08, 0);
      rd(8'h18, d); check("R8 error set", d, stat(0, 0, 1));
      wr(8'h18, 0);
      rd(8'h18, d); check("R8 error sticky", d, stat(0, 0, 1));
      wr(8'h18, 32'h0000_0100);
      rd(8'h18, d); check("R8 error cleared", d, 0);

      // R6 fast path: ch15 pri4, ch14 pri6
      set_cfg(15, 4, 1'b1);
      set_cfg(14, 6, 1'b1);
      @(negedge clk); req = 16'h8000;
      settle();
      check("R6 fiq_o raised", 32'(fiq_o), 1);
      check("R6 irq_o quiet", 32'(irq_o), 0);
      rd(8'h00, d); check("R7 irq vec with only fast", d, DFLT);
      rd(8'h04, d); check("R6 fast vector", d, vecof(winner(16'h8000, 1'b1, -1)));
      settle();
      check("R6 busy lowers fiq_o", 32'(fiq_o), 0);
      @(negedge clk); req = 16'hC000;
      settle();
      check("R6 no nesting", 32'(fiq_o), 0);
      rd(8'h04, d); check("R6 busy read default", d, DFLT);
      wr(8'h0C, 32'h1234_5678);
      settle();
      check("R6 end releases", 32'(fiq_o), 1);
      rd(8'h04, d); check("R6 higher fast wins", d, vecof(14));
      wr(8'h0C, 0);
      @(negedge clk); req = '0;
      rd(8'h18, d); check("R6 stack untouched", d, 0);

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule